// File: doc/BRIEF.md
# Error-Tolerant Sync Word Tracker

This block watches a serial bit stream, one bit per accepted transfer, for a fixed synchronisation pattern. It tolerates a programmable number of wrong bits in the pattern. The most recent `SYNC_LEN` received bits form a candidate window. On every new bit the window is compared with the pattern, and the number of differing positions is counted. When that count is at or below the 3-bit limit, the block takes the word as a valid sync. It then emits a one-cycle pulse, records the count, raises the lock flag and flags an interrupt.

Downstream frame logic uses the pulse to capture the frame that follows. Lock is kept across frames whose sync word is too damaged to accept. Lock is given up only after more than `LOSS_BITS` received bits have gone by with no acceptable sync word. Losing lock also raises the interrupt for one cycle.

The bit input is a valid/ready stream. The block never applies back-pressure, so `in_ready` is high whenever the block is out of reset. A bit is consumed on every rising edge where `in_valid` is high. Cycles with `in_valid` low carry no bit and have no effect on the window or on the loss counter.

Top module: `sync_tracker`

## Requirements
- R1: A valid sync is declared on the edge that consumes a bit when both of the following hold. First, at least `SYNC_LEN` bits have been consumed since reset. Second, the count of positions where the last `SYNC_LEN` bits differ from `SYNC_WORD` is less than or equal to `err_limit`. The bits are compared with the oldest bit against the pattern MSB.
- R2: After a valid sync, `sync_pulse` is high for exactly the one cycle that follows the consuming edge. In that cycle `sync_errs` shows the mismatch count of the accepted word.
- R3: `sync_errs` keeps its value whenever no sync is accepted, including when a full window exceeds the limit.
- R4: Each accepted sync sets `locked` to 1.
- R5: `locked` falls to 0 on the consuming edge of the 421st consecutive consumed bit (`LOSS_BITS`+1) that yields no accepted sync. Cycles without `in_valid` do not count.
- R6: `irq` is high for one cycle after each accepted sync and one cycle after each loss of lock.
- R7: A cycle with `in_valid` low neither shifts the window nor produces a sync. Bits separated by idle cycles form the same window as back-to-back bits.
- R8: Synchronous active-high `rst` clears `locked`, `sync_errs`, `sync_pulse`, `irq`, the window fill count and the loss counter.
- R9: `in_ready` is 1 whenever `rst` is low, so no bit is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A serial bit is offered this cycle |
| in_ready | output | 1 | Block accepts the offered bit (constant 1 out of reset) |
| in_bit | input | 1 | Serial data bit |
| err_limit | input | 3 | Largest tolerated number of pattern mismatches |
| locked | output | 1 | Lock status flag |
| sync_errs | output | 3 | Mismatch count of the last accepted sync word |
| sync_pulse | output | 1 | One-cycle strobe per accepted sync |
| irq | output | 1 | One-cycle interrupt request on sync or loss of lock |

## Verification
The bench uses an 8-bit pattern and sweeps every limit from 0 to 7 against words with 0 to 8 flipped bits, with the flip positions rotated between runs. This pins down the accept-or-reject boundary and the reported count. A run with a tight limit and a hostile tail shows that a rejected candidate leaves the count alone. Bits spaced by idle cycles show that the window only moves on valid transfers. A long stream with no sync word, interleaved with idle gaps, separates bit 420 from bit 421 for loss of lock. A pseudo-random stream under a mid-range limit exercises overlapping candidate windows and back-to-back acceptances against an arithmetic reference.

// File: rtl/sync_tracker_pkg.sv
package sync_tracker_pkg;
  localparam int ERR_W = 3;
  typedef logic [ERR_W-1:0] err_cnt_t;
endpackage

// File: rtl/sync_window.sv
module sync_window #(
  parameter int SYNC_LEN = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift,
  input  logic                din,
  output logic [SYNC_LEN-1:0] cand,
  output logic                cand_full
);
  localparam int FILL_W = $clog2(SYNC_LEN);

  logic [SYNC_LEN-1:0] win_q;
  logic [FILL_W-1:0]   fill_q;

  // candidate includes the bit being consumed on this edge
  assign cand      = {win_q[SYNC_LEN-2:0], din};
  assign cand_full = (fill_q == FILL_W'(SYNC_LEN-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift) begin
      win_q <= cand;
      if (!cand_full) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_mismatch.sv
module sync_mismatch #(
  parameter int                SYNC_LEN  = 24,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = '0,
  localparam int               CNT_W     = $clog2(SYNC_LEN + 1)
) (
  input  logic [SYNC_LEN-1:0] cand,
  output logic [CNT_W-1:0]    miss
);
  logic [SYNC_LEN-1:0] diff;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_LEN; gi++) begin : g_diff
      assign diff[gi] = cand[gi] ^ SYNC_WORD[gi];
    end
  endgenerate

  always_comb begin
    miss = '0;
    for (int i = 0; i < SYNC_LEN; i++) miss = miss + CNT_W'(diff[i]);
  end
endmodule

// File: rtl/sync_lock_ctrl.sv
module sync_lock_ctrl
  import sync_tracker_pkg::*;
#(
  parameter int  CNT_W     = 5,
  parameter int  LOSS_BITS = 420
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             eval,
  input  logic [CNT_W-1:0] miss,
  input  err_cnt_t         limit,
  output logic             locked,
  output err_cnt_t         errs,
  output logic             pulse,
  output logic             irq
);
  localparam int GAP_W = $clog2(LOSS_BITS + 1);
  localparam int CMP_W = (CNT_W > ERR_W) ? CNT_W : ERR_W;

  logic [GAP_W-1:0] gap_q;
  logic             accept;

  assign accept = eval && (CMP_W'(miss) <= CMP_W'(limit));

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      errs   <= '0;
      pulse  <= 1'b0;
      irq    <= 1'b0;
      gap_q  <= '0;
    end else begin
      pulse <= 1'b0;
      irq   <= 1'b0;
      if (accept) begin
        pulse  <= 1'b1;
        irq    <= 1'b1;
        locked <= 1'b1;
        errs   <= err_cnt_t'(miss);
        gap_q  <= '0;
      end else if (step) begin
        if (gap_q == GAP_W'(LOSS_BITS)) begin
          if (locked) begin
            locked <= 1'b0;
            irq    <= 1'b1;
          end
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_tracker.sv
module sync_tracker
  import sync_tracker_pkg::*;
#(
  parameter int                  SYNC_LEN  = 24,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 24'hF26B1C,
  parameter int                  LOSS_BITS = 420
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  input  logic [ERR_W-1:0] err_limit,
  output logic            locked,
  output logic [ERR_W-1:0] sync_errs,
  output logic            sync_pulse,
  output logic            irq
);
  localparam int CNT_W = $clog2(SYNC_LEN + 1);

  logic [SYNC_LEN-1:0] cand;
  logic                cand_full;
  logic [CNT_W-1:0]    miss;

  assign in_ready = 1'b1;

  sync_window #(.SYNC_LEN(SYNC_LEN)) u_win (
    .clk(clk), .rst(rst), .shift(in_valid), .din(in_bit),
    .cand(cand), .cand_full(cand_full)
  );

  sync_mismatch #(.SYNC_LEN(SYNC_LEN), .SYNC_WORD(SYNC_WORD)) u_cmp (
    .cand(cand), .miss(miss)
  );

  sync_lock_ctrl #(.CNT_W(CNT_W), .LOSS_BITS(LOSS_BITS)) u_ctl (
    .clk(clk), .rst(rst), .step(in_valid), .eval(in_valid && cand_full),
    .miss(miss), .limit(err_limit),
    .locked(locked), .errs(sync_errs), .pulse(sync_pulse), .irq(irq)
  );
endmodule

// File: rtl/sync_tracker_chk.sv
module sync_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [2:0] err_limit,
  input logic       locked,
  input logic [2:0] sync_errs,
  input logic       sync_pulse,
  input logic       irq
);
  p_errs_within_limit_r1: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> sync_errs <= $past(err_limit));
  p_errs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sync_pulse |-> $stable(sync_errs));
  p_pulse_locked_r4: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> locked);
  p_drop_on_bit_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(in_valid));
  p_irq_on_sync_r6: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> irq);
  p_irq_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> irq);
  p_pulse_needs_bit_r7: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(in_valid));
endmodule

bind sync_tracker sync_tracker_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .err_limit(err_limit),
  .locked(locked), .sync_errs(sync_errs), .sync_pulse(sync_pulse), .irq(irq)
);

// File: tb/sync_tracker_test.sv
module sync_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 8;
  localparam logic [LEN-1:0] PAT = 8'hB4;
  localparam int LOSS = 420;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic [2:0] err_limit = 3'd0;
  logic in_ready, locked, sync_pulse, irq;
  logic [2:0] sync_errs;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [LEN-1:0] m_win;
  int m_fill, m_gap, m_errs;
  logic m_lock, m_pulse, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tracker #(.SYNC_LEN(LEN), .SYNC_WORD(PAT), .LOSS_BITS(LOSS)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .err_limit(err_limit), .locked(locked),
    .sync_errs(sync_errs), .sync_pulse(sync_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_win = '0; m_fill = 0; m_gap = 0; m_errs = 0;
    m_lock = 0; m_pulse = 0; m_irq = 0;
  endtask

  task automatic model_step(input logic v, input logic b);
    logic [LEN-1:0] w;
    int miss;
    m_pulse = 0; m_irq = 0;
    if (v) begin
      w = {m_win[LEN-2:0], b};
      miss = $countones(w ^ PAT);
      if (m_fill >= LEN-1 && miss <= int'(err_limit)) begin
        m_pulse = 1; m_irq = 1; m_lock = 1; m_errs = miss; m_gap = 0;
      end else if (m_gap == LOSS) begin
        if (m_lock) begin m_lock = 0; m_irq = 1; end
      end else m_gap++;
      m_win = w;
      if (m_fill < LEN-1) m_fill++;
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " locked R4/R5"}, int'(locked), int'(m_lock));
    chk({tag, " errs R2/R3"}, int'(sync_errs), m_errs);
    chk({tag, " pulse R1/R2"}, int'(sync_pulse), int'(m_pulse));
    chk({tag, " irq R6"}, int'(irq), int'(m_irq));
  endtask

  task automatic send(input logic b, input string tag);
    in_valid = 1'b1; in_bit = b;
    model_step(1'b1, b);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    model_step(1'b0, 1'b0);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic send_word(input logic [LEN-1:0] w, input string tag);
    for (int i = LEN-1; i >= 0; i--) send(w[i], tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    // R8 reset state, R9 ready
    chk("R8 locked after reset", int'(locked), 0);
    chk("R8 errs after reset", int'(sync_errs), 0);
    chk("R8 pulse after reset", int'(sync_pulse), 0);
    chk("R8 irq after reset", int'(irq), 0);
    chk("R9 ready", int'(in_ready), 1);

    // R1/R2 sweep: every limit against 0..8 flipped bits
    for (int lim = 0; lim < 8; lim++) begin
      for (int e = 0; e <= LEN; e++) begin
        logic [2*LEN-1:0] m2;
        logic [LEN-1:0] mask;
        do_reset();
        err_limit = 3'(lim);
        m2 = (16'(1) << e) - 16'd1;
        m2 = m2 << lim;
        mask = m2[LEN-1:0] | m2[2*LEN-1:LEN];
        send_word(PAT ^ mask, "R1 sweep");
        chk("R1 accept boundary", int'(sync_pulse), (e <= lim) ? 1 : 0);
        chk("R2 errs value", int'(sync_errs), (e <= lim) ? e : 0);
      end
    end

    // R3: count held when later candidates are rejected
    do_reset();
    err_limit = 3'd2;
    send_word(PAT ^ 8'h01, "R3 first");
    chk("R3 first errs", int'(sync_errs), 1);
    err_limit = 3'd0;
    send_word(~PAT, "R3 reject");
    chk("R3 errs held", int'(sync_errs), 1);

    // R7: idle cycles between bits
    do_reset();
    err_limit = 3'd0;
    for (int i = LEN-1; i >= 0; i--) begin
      send(PAT[i], "R7 spaced");
      idle("R7 gap");
      chk("R7 no pulse in gap", int'(sync_pulse), 0);
    end
    chk("R7 spaced word locked", int'(locked), 1);

    // R5: loss after 421 bits without sync, idles not counted
    do_reset();
    err_limit = 3'd0;
    send_word(PAT, "R5 lock");
    chk("R5 locked", int'(locked), 1);
    for (int i = 1; i <= LOSS; i++) begin
      send(1'b0, "R5 run");
      if (i % 100 == 0) begin idle("R5 idle"); idle("R5 idle"); end
    end
    chk("R5 still locked at 420", int'(locked), 1);
    send(1'b0, "R5 421st");
    chk("R5 dropped at 421", int'(locked), 0);
    chk("R6 irq on drop", int'(irq), 1);
    send(1'b0, "R5 after");
    chk("R6 irq one cycle", int'(irq), 0);

    // pseudo-random stream
    do_reset();
    err_limit = 3'd3;
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) idle("R7 random idle");
      else send(lfsr[0], "R1 random");
    end

    in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule